// File: doc/BRIEF.md
# Bit-Addressed Open-Drain Port

This block is an eight-pin general-purpose port that software drives one pin at a time. A pointer value picks the pin. Four command strobes act on the port: raise the chosen pin's latch, lower it, raise all latches at once, or test the chosen pin's level. Each pad is open-drain. A latch at 0 enables the pad driver, which pulls the pad low. A latch at 1 releases the pad to high impedance, and a pull-up then supplies the high level. When a pin is used as an input, its latch must first be raised. Otherwise the pin's own driver holds it low.

A test command reports its result one cycle later as a single-cycle skip indication. The sequencer that issues the commands uses that indication to pass over its next instruction. A pointer value outside the eight pins makes a set, lower or test command do nothing, and an error pulse reports it. The two highest pins can be handed to counter inputs through two mode bits. While a pin is in counter mode its driver stays off, and its synchronised level is routed to the counter.

Top module: `bitsel_od_port`

## Requirements
- R1: After reset the following hold: every latch is 1, so `pad_oe_o` is all zero; both mode bits select port mode; `skip_o`, `err_o` and `cnt_in_o` are 0; and the synchronisers hold all ones.
- R2: A set strobe (`set_i`) with pointer below 8 writes 1 to the chosen latch, so that pin's `pad_oe_o` bit is 0 from the next cycle.
- R3: A lower strobe (`clr_i`) with pointer below 8 writes 0 to the chosen latch, so that pin's `pad_oe_o` bit is 1 from the next cycle unless the pin is in counter mode. `pad_do_o` is always all zero. If set and lower arrive together, lower wins.
- R4: A release-all strobe (`rel_all_i`) writes 1 to all eight latches in one cycle, so `pad_oe_o` is all zero in the next cycle. It overrides any set or lower strobe in the same cycle.
- R5: A test strobe (`test_i`) with pointer below 8 raises `skip_o` for exactly the next cycle when the chosen pin's read-back level in the command cycle is 0. The read-back level is taken before that cycle's latch update. When the level is 1, `skip_o` stays 0.
- R6: `rd_o[i]` equals the pad level passed through two flops, ANDed with latch i. A change on `pad_in_i` appears on `rd_o` after the second clock edge.
- R7: A set, lower or test strobe whose pointer is 8 or more changes no latch and raises no skip. It raises `err_o` for exactly the next cycle.
- R8: Loading the mode bits with `mode_we_i`, where bit k selects counter mode for pin 6+k, forces that pin's `pad_oe_o` bit to 0 from the next cycle. In counter mode `cnt_in_o[k]` carries the synchronised level of pin 6+k. In port mode it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| ptr_i | input | 4 | Pin pointer; values 8 to 15 are invalid |
| set_i | input | 1 | Set chosen latch (release pin) |
| clr_i | input | 1 | Clear chosen latch (drive pin low) |
| rel_all_i | input | 1 | Set all latches |
| test_i | input | 1 | Test chosen pin level |
| mode_we_i | input | 1 | Load counter-mode bits |
| mode_d_i | input | 2 | New counter-mode bits for pins 6 and 7 |
| pad_in_i | input | 8 | Pad levels |
| pad_oe_o | output | 8 | Pad driver enable, high drives low |
| pad_do_o | output | 8 | Pad driven value, always 0 |
| rd_o | output | 8 | Synchronised read-back levels |
| skip_o | output | 1 | Test found the pin low |
| err_o | output | 1 | Command used an invalid pointer |
| cnt_in_o | output | 2 | Counter inputs from pins 6 and 7 |

## Verification
The assertions assume that the strobes are sampled on the clock edge, and that `ptr_i` and `mode_d_i` are stable at that edge together with their strobes. They place no limit on how many strobes arrive at once. The stimulus changes every input only on the falling edge. It issues commands in any combination, including pointers from 0 to 9 and simultaneous set, lower and release-all. It resolves each pad from a model of the open-drain wiring, so a driven pin always reads low at the pad.

// File: rtl/bitsel_od_port.sv
module bitsel_od_port #(
  parameter int N_PINS = 8,
  parameter int PTR_W  = 4,
  parameter int N_ALT  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [PTR_W-1:0]  ptr_i,
  input  logic              set_i,
  input  logic              clr_i,
  input  logic              rel_all_i,
  input  logic              test_i,
  input  logic              mode_we_i,
  input  logic [N_ALT-1:0]  mode_d_i,
  input  logic [N_PINS-1:0] pad_in_i,
  output logic [N_PINS-1:0] pad_oe_o,
  output logic [N_PINS-1:0] pad_do_o,
  output logic [N_PINS-1:0] rd_o,
  output logic              skip_o,
  output logic              err_o,
  output logic [N_ALT-1:0]  cnt_in_o
);
  localparam int IDX_W    = $clog2(N_PINS);
  localparam int ALT_BASE = N_PINS - N_ALT;

  logic [N_PINS-1:0] latch_q, sync1_q, sync2_q, alt_mask;
  logic [N_ALT-1:0]  mode_q;
  logic [IDX_W-1:0]  idx;
  logic              valid, cmd, skip_q, err_q;

  assign idx   = ptr_i[IDX_W-1:0];
  assign valid = (ptr_i < PTR_W'(N_PINS));
  assign cmd   = set_i | clr_i | test_i;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      latch_q <= '1;
    end else if (rel_all_i) begin
      latch_q <= '1;
    end else if (valid) begin
      if (clr_i)      latch_q[idx] <= 1'b0;
      else if (set_i) latch_q[idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      sync1_q <= '1;
      sync2_q <= '1;
    end else begin
      sync1_q <= pad_in_i;
      sync2_q <= sync1_q;
    end
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      skip_q <= 1'b0;
      err_q  <= 1'b0;
      mode_q <= '0;
    end else begin
      skip_q <= test_i & valid & ~rd_o[idx];
      err_q  <= cmd & ~valid;
      if (mode_we_i) mode_q <= mode_d_i;
    end
  end

  generate
    for (genvar i = 0; i < N_PINS; i++) begin : g_mask
      if (i >= ALT_BASE) begin : g_alt
        assign alt_mask[i] = mode_q[i-ALT_BASE];
      end else begin : g_port
        assign alt_mask[i] = 1'b0;
      end
    end
  endgenerate

  assign rd_o     = sync2_q & latch_q;
  assign pad_oe_o = ~latch_q & ~alt_mask;
  assign pad_do_o = '0;
  assign skip_o   = skip_q;
  assign err_o    = err_q;
  assign cnt_in_o = mode_q & sync2_q[ALT_BASE +: N_ALT];

  AST_SET_RELEASES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i && !clr_i && !rel_all_i && valid) |=> !pad_oe_o[$past(idx)]); // R2

  AST_CLR_DRIVES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !rel_all_i && valid && (int'(idx) < ALT_BASE)) |=> pad_oe_o[$past(idx)]); // R3

  AST_REL_ALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rel_all_i |=> (pad_oe_o == '0)); // R4

  AST_SKIP_SOURCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    skip_o |-> ($past(test_i) && $past(valid))); // R5

  AST_BAD_PTR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd && !valid) |=> (err_o && !skip_o)); // R7

  generate
    for (genvar k = 0; k < N_ALT; k++) begin : g_alt_chk
      AST_ALT_NO_DRIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mode_we_i && mode_d_i[k]) |=> !pad_oe_o[ALT_BASE+k]); // R8
    end
  endgenerate
endmodule

// File: tb/bitsel_od_port_tb.sv
module bitsel_od_port_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] ptr = '0;
  logic       set_s = 0, clr_s = 0, rel_s = 0, tst_s = 0, mwe = 0;
  logic [1:0] md = '0;
  logic [7:0] ext = 8'hFF;
  logic [7:0] pad_in, oe, dout, rd;
  logic       skip, err;
  logic [1:0] cnt;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2ns clk = ~clk;

  logic [7:0] m_lat = 8'hFF, m_s1 = 8'hFF, m_s2 = 8'hFF;
  logic [1:0] m_mode = '0;
  logic       m_skip = 0, m_err = 0;
  logic [7:0] m_oe;

  assign m_oe   = ~m_lat & ~{m_mode, 6'b0};
  assign pad_in = ext & ~m_oe;

  bitsel_od_port dut_i (
    .clk_i(clk), .rst_ni(rst_n), .ptr_i(ptr), .set_i(set_s), .clr_i(clr_s),
    .rel_all_i(rel_s), .test_i(tst_s), .mode_we_i(mwe), .mode_d_i(md),
    .pad_in_i(pad_in), .pad_oe_o(oe), .pad_do_o(dout), .rd_o(rd),
    .skip_o(skip), .err_o(err), .cnt_in_o(cnt));

  function automatic logic [7:0] next_lat(logic [7:0] l, logic s, logic c, logic r, int p);
    if (r) return 8'hFF;
    if (p < 8) begin
      if (c) l[p] = 1'b0;
      else if (s) l[p] = 1'b1;
    end
    return l;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_lat <= 8'hFF; m_s1 <= 8'hFF; m_s2 <= 8'hFF;
      m_mode <= '0; m_skip <= 0; m_err <= 0;
    end else begin
      m_lat  <= next_lat(m_lat, set_s, clr_s, rel_s, int'(ptr));
      m_s1   <= pad_in;
      m_s2   <= m_s1;
      m_skip <= tst_s && (ptr < 8) && !(m_s2[ptr[2:0]] & m_lat[ptr[2:0]]);
      m_err  <= (set_s || clr_s || tst_s) && (ptr >= 8);
      if (mwe) m_mode <= md;
    end
  end

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(oe === m_oe, "R2 R3 R4 R8 pad_oe", 32'(oe), 32'(m_oe));
      check(dout === 8'h00, "R3 pad_do", 32'(dout), 0);
      check(rd === (m_s2 & m_lat), "R6 rd", 32'(rd), 32'(m_s2 & m_lat));
      check(skip === m_skip, "R5 skip", 32'(skip), 32'(m_skip));
      check(err === m_err, "R7 err", 32'(err), 32'(m_err));
      check(cnt === (m_mode & m_s2[7:6]), "R8 cnt", 32'(cnt), 32'(m_mode & m_s2[7:6]));
    end
  end

  task automatic step(logic s, logic c, logic r, logic t, int p);
    set_s = s; clr_s = c; rel_s = r; tst_s = t; ptr = 4'(p);
    @(negedge clk);
    set_s = 0; clr_s = 0; rel_s = 0; tst_s = 0; mwe = 0;
  endtask

  initial begin
    #(4ns * 150000);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(oe == 8'h00 && skip == 0 && err == 0 && cnt == 0, "R1 reset outputs", 32'({oe, skip, err, cnt}), 0);
    check(rd == 8'hFF, "R1 reset read-back", 32'(rd), 32'hFF);

    step(0, 1, 0, 0, 2);
    check(oe == 8'h04, "R3 lower pin 2", 32'(oe), 32'h04);
    step(1, 1, 0, 0, 4);
    check(oe == 8'h14, "R3 lower wins over set", 32'(oe), 32'h14);
    step(0, 0, 0, 0, 0);
    step(0, 0, 0, 1, 2);
    check(skip == 1'b1, "R5 skip on low pin", 32'(skip), 1);
    step(0, 0, 0, 0, 0);
    check(skip == 1'b0, "R5 skip one cycle", 32'(skip), 0);
    step(0, 0, 0, 1, 3);
    check(skip == 1'b0, "R5 no skip on high pin", 32'(skip), 0);
    step(1, 0, 0, 0, 2);
    check(oe == 8'h10, "R2 set releases pin 2", 32'(oe), 32'h10);

    step(1, 0, 0, 0, 9);
    check(err == 1'b1 && oe == 8'h10, "R7 invalid set", 32'({err, oe}), 32'h110);
    step(0, 1, 0, 0, 12);
    check(err == 1'b1 && oe == 8'h10, "R7 invalid lower", 32'({err, oe}), 32'h110);
    step(0, 0, 0, 1, 8);
    check(err == 1'b1 && skip == 1'b0, "R7 invalid test", 32'({err, skip}), 32'h2);
    step(0, 0, 0, 0, 0);
    check(err == 1'b0, "R7 error one cycle", 32'(err), 0);

    step(0, 1, 0, 0, 1);
    step(0, 1, 0, 0, 5);
    check(oe == 8'h32, "R3 several low", 32'(oe), 32'h32);
    step(1, 1, 1, 0, 0);
    check(oe == 8'h00, "R4 release all wins", 32'(oe), 0);

    step(0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0);
    ext = 8'hF7;
    step(0, 0, 0, 0, 0);
    check(rd == 8'hFF, "R6 one edge not yet visible", 32'(rd), 32'hFF);
    step(0, 0, 0, 0, 0);
    check(rd == 8'hF7, "R6 visible after two edges", 32'(rd), 32'hF7);

    mwe = 1; md = 2'b01;
    step(0, 1, 0, 0, 6);
    check(oe[6] == 1'b0, "R8 counter pin not driven", 32'(oe), 0);
    check(cnt == 2'b01, "R8 counter input high", 32'(cnt), 1);
    ext = 8'hB7;
    step(0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0);
    check(cnt == 2'b00, "R8 counter input follows pin", 32'(cnt), 0);
    mwe = 1; md = 2'b00;
    step(0, 0, 0, 0, 0);
    check(oe == 8'h40 && cnt == 2'b00, "R8 back to port mode", 32'({oe, cnt}), 32'h100);
    ext = 8'hFF;

    for (int n = 0; n < 4000; n++) begin
      if ($urandom_range(0, 15) == 0) ext = 8'($urandom);
      if ($urandom_range(0, 19) == 0) begin
        mwe = 1; md = 2'($urandom);
      end
      step($urandom_range(0, 3) == 0, $urandom_range(0, 3) == 0,
           $urandom_range(0, 11) == 0, $urandom_range(0, 2) == 0,
           int'($urandom_range(0, 9)));
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule